// File: doc/BRIEF.md
# Registered Bidirectional Pad Buffer

This block sits between core logic and a group of tri-state pad wires. It places a flip-flop on each of three paths: the data the core wants to drive, the single enable that decides whether the group is driven, and the value sampled back from the wires. The data and enable flops run on an output clock. The sampling flop runs on an input clock, which may be a different clock. Both clocks are rising-edge. None of the flops has a reset. Each flop starts from a declared power-up value instead.

The parameter `DIR` selects the variant: `PB_IN` (0) builds only the sampling path, `PB_OUT` (1) builds only the driving paths, and `PB_BIDIR` (2) builds all three. The parameter `INVERT` has one bit per wire. A set bit flips that wire both on the way out and on the way back. The pad side has three ports: the registered drive value, the registered enable and the raw wire value. The surrounding tri-state net is resolved outside the block. Whenever the enable is low, the wires are released to the far side.

Top module: `regd_pad_buffer`

## Requirements
- R1: One `out_clk` rising edge after `core_o` is presented, `pad_o` equals `core_o` XOR `INVERT`, bit by bit.
- R2: `pad_oe` equals the `core_oe` value captured at the previous `out_clk` rising edge. While `pad_oe` is 0, the block does not drive the wires, and the net carries the far side's value.
- R3: After each `in_clk` rising edge, `core_i` equals the `pad_i` value present at that edge, XOR `INVERT`.
- R4: Before any clock edge, `pad_oe` is 0 when `DIR` is `PB_BIDIR` (2) and 1 when `DIR` is `PB_OUT` (1).
- R5: In bidirectional mode with both clocks tied together and the block driving, a word placed on `core_o` returns unchanged on `core_i` two edges later, because the two inversions cancel.
- R6: When `DIR` is `PB_IN` (0), `pad_oe` and `pad_o` stay 0 whatever `core_o` and `core_oe` do.
- R7: When `DIR` is `PB_OUT` (1), `core_i` stays 0 whatever `pad_i` does.
- R8: `core_i` changes only on a rising edge of `in_clk`. Edges of `out_clk` alone leave it unchanged.
- R9: A far-side driver that starts one cycle after `core_o` has seen `core_oe` fall never overlaps the block's drive, because `pad_oe` falls exactly one edge after `core_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| out_clk | input | 1 | Clock for the drive-data and enable flops |
| in_clk | input | 1 | Clock for the sampling flop |
| core_o | input | WIDTH | Data the core wants on the wires (ignored in input-only mode) |
| core_oe | input | 1 | Core request to drive the wires (ignored in input-only mode) |
| pad_o | output | WIDTH | Registered, polarity-adjusted drive value |
| pad_oe | output | 1 | Registered drive enable for the whole group |
| pad_i | input | WIDTH | Value seen on the wires (ignored in output-only mode) |
| core_i | output | WIDTH | Registered, polarity-adjusted sampled value |

## Verification
Because every path is a single flop, a wrong stored value shows at the matching port after the very next edge of its own clock. A misplaced inversion bit appears as a fixed per-bit difference on `pad_o` or `core_i`. It also survives a loopback as a doubled flip, which the two-edge round trip exposes. An enable flop loaded a cycle early or late shows as contention, or as a stale value, at the burst boundaries. A wrong power-up value shows on `pad_oe` before the first edge. A sampling flop clocked by the wrong clock shows as `core_i` moving while `in_clk` is held still.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;

   typedef enum logic [1:0] {
      PB_IN    = 2'd0,
      PB_OUT   = 2'd1,
      PB_BIDIR = 2'd2
   } pb_dir_e;

   function automatic logic oe_power_up(pb_dir_e d);
      return (d == PB_OUT);
   endfunction

   function automatic logic has_drive(pb_dir_e d);
      return (d == PB_OUT) || (d == PB_BIDIR);
   endfunction

   function automatic logic has_sample(pb_dir_e d);
      return (d == PB_IN) || (d == PB_BIDIR);
   endfunction

endpackage

// File: rtl/pbuf_out_stage.sv
module pbuf_out_stage #(
   parameter int                 WIDTH   = 8,
   parameter logic [WIDTH-1:0]   INVERT  = '0,
   parameter logic               OE_INIT = 1'b0
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] core_o,
   input  logic             core_oe,
   output logic [WIDTH-1:0] pad_o,
   output logic             pad_oe
);

   logic [WIDTH-1:0] polar;
   logic [WIDTH-1:0] o_q   = '0;
   logic             oe_q  = OE_INIT;
   logic             primed = 1'b0;

   for (genvar b = 0; b < WIDTH; b++) begin : g_pol
      if (INVERT[b]) begin : g_flip
         assign polar[b] = ~core_o[b];
      end else begin : g_pass
         assign polar[b] = core_o[b];
      end
   end

   always_ff @(posedge clk) begin
      o_q    <= polar;
      oe_q   <= core_oe;
      primed <= 1'b1;
   end

   assign pad_o  = o_q;
   assign pad_oe = oe_q;

   // R2: the enable reaches the pad one edge after the core asks for it
   p_oe_lat_r2: assert property (@(posedge clk) disable iff (!primed)
      pad_oe == $past(core_oe));

   // R1: steady core request gives a steady pad one edge later
   p_out_steady_r1: assert property (@(posedge clk) disable iff (!primed)
      ($stable(core_o) && $stable(core_oe)) |=> ($stable(pad_o) && $stable(pad_oe)));

endmodule

// File: rtl/pbuf_in_stage.sv
module pbuf_in_stage #(
   parameter int               WIDTH  = 8,
   parameter logic [WIDTH-1:0] INVERT = '0
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] pad_i,
   output logic [WIDTH-1:0] core_i
);

   logic [WIDTH-1:0] polar;
   logic [WIDTH-1:0] i_q    = '0;
   logic             primed = 1'b0;

   for (genvar b = 0; b < WIDTH; b++) begin : g_pol
      if (INVERT[b]) begin : g_flip
         assign polar[b] = ~pad_i[b];
      end else begin : g_pass
         assign polar[b] = pad_i[b];
      end
   end

   always_ff @(posedge clk) begin
      i_q    <= polar;
      primed <= 1'b1;
   end

   assign core_i = i_q;

   // R3: sampled word arrives one input edge later with the mask applied
   p_in_lat_r3: assert property (@(posedge clk) disable iff (!primed)
      core_i == ($past(pad_i) ^ INVERT));

   // R8: unchanged wires leave the core side unchanged
   p_in_steady_r8: assert property (@(posedge clk) disable iff (!primed)
      $stable(pad_i) |=> $stable(core_i));

endmodule

// File: rtl/regd_pad_buffer.sv
module regd_pad_buffer
   import pbuf_pkg::*;
#(
   parameter int               WIDTH  = 8,
   parameter pb_dir_e          DIR    = PB_BIDIR,
   parameter logic [WIDTH-1:0] INVERT = '0
) (
   input  logic             out_clk,
   input  logic             in_clk,
   input  logic [WIDTH-1:0] core_o,
   input  logic             core_oe,
   output logic [WIDTH-1:0] pad_o,
   output logic             pad_oe,
   input  logic [WIDTH-1:0] pad_i,
   output logic [WIDTH-1:0] core_i
);

   localparam logic OE_INIT   = oe_power_up(DIR);
   localparam logic DRIVES    = has_drive(DIR);
   localparam logic SAMPLES   = has_sample(DIR);

   if (WIDTH < 1) begin : g_bad_width
      $error("regd_pad_buffer: WIDTH must be at least 1");
   end
   if (!DRIVES && !SAMPLES) begin : g_bad_dir
      $error("regd_pad_buffer: DIR must select input, output or both");
   end

   if (DRIVES) begin : g_drive
      pbuf_out_stage #(
         .WIDTH   (WIDTH),
         .INVERT  (INVERT),
         .OE_INIT (OE_INIT)
      ) u_out (
         .clk     (out_clk),
         .core_o  (core_o),
         .core_oe (core_oe),
         .pad_o   (pad_o),
         .pad_oe  (pad_oe)
      );
   end else begin : g_no_drive
      wire unused_drive_side = &{1'b0, out_clk, core_o, core_oe};
      assign pad_o  = '0;
      assign pad_oe = 1'b0;
   end

   if (SAMPLES) begin : g_sample
      pbuf_in_stage #(
         .WIDTH  (WIDTH),
         .INVERT (INVERT)
      ) u_in (
         .clk    (in_clk),
         .pad_i  (pad_i),
         .core_i (core_i)
      );
   end else begin : g_no_sample
      wire unused_sample_side = &{1'b0, in_clk, pad_i};
      assign core_i = '0;
   end

endmodule

// File: tb/tb_regd_pad_buffer.sv
module tb_regd_pad_buffer;
   import pbuf_pkg::*;

   localparam int         W     = 8;
   localparam logic [W-1:0] INV_B = 8'hA5;
   localparam logic [W-1:0] INV_O = 8'h0F;
   localparam logic [W-1:0] INV_I = 8'h3C;

   logic clk  = 1'b0;
   logic iclk = 1'b0;
   always #5 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   int contention = 0;
   bit done = 0;

   // bidirectional instance with a modelled far side
   logic [W-1:0] b_core_o = '0;
   logic         b_core_oe = 1'b0;
   logic [W-1:0] b_pad_o, b_core_i;
   logic         b_pad_oe;
   logic         ext_en = 1'b0;
   logic [W-1:0] ext_val = '0;
   wire  [W-1:0] pad_net = b_pad_oe ? b_pad_o : ext_val;

   // output-only instance
   logic [W-1:0] o_core_o = '0;
   logic         o_core_oe = 1'b1;
   logic [W-1:0] o_pin = '0;
   logic [W-1:0] o_pad_o, o_core_i;
   logic         o_pad_oe;

   // input-only instance with its own hand-driven clock
   logic [W-1:0] i_core_o = '0;
   logic         i_core_oe = 1'b0;
   logic [W-1:0] i_pin = '0;
   logic [W-1:0] i_pad_o, i_core_i;
   logic         i_pad_oe;

   regd_pad_buffer #(.WIDTH(W), .DIR(PB_BIDIR), .INVERT(INV_B)) dut (
      .out_clk(clk), .in_clk(clk), .core_o(b_core_o), .core_oe(b_core_oe),
      .pad_o(b_pad_o), .pad_oe(b_pad_oe), .pad_i(pad_net), .core_i(b_core_i));

   regd_pad_buffer #(.WIDTH(W), .DIR(PB_OUT), .INVERT(INV_O)) dut_o (
      .out_clk(clk), .in_clk(clk), .core_o(o_core_o), .core_oe(o_core_oe),
      .pad_o(o_pad_o), .pad_oe(o_pad_oe), .pad_i(o_pin), .core_i(o_core_i));

   regd_pad_buffer #(.WIDTH(W), .DIR(PB_IN), .INVERT(INV_I)) dut_i (
      .out_clk(clk), .in_clk(iclk), .core_o(i_core_o), .core_oe(i_core_oe),
      .pad_o(i_pad_o), .pad_oe(i_pad_oe), .pad_i(i_pin), .core_i(i_core_i));

   function automatic logic [W-1:0] polar(logic [W-1:0] v, logic [W-1:0] m);
      return v ^ m;
   endfunction

   task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // snapshot of inputs present at the coming edge
   bit           have_snap = 0;
   logic [W-1:0] s_core_o, s_net, s_o_core_o;
   logic         s_oe, s_o_oe;

   task automatic step();
      @(negedge clk);
      if (have_snap) begin
         chk("R1", "bidir pad_o", b_pad_o, polar(s_core_o, INV_B));
         chk("R2", "bidir pad_oe", {7'd0, b_pad_oe}, {7'd0, s_oe});
         chk("R3", "bidir core_i", b_core_i, polar(s_net, INV_B));
         chk("R1", "out pad_o", o_pad_o, polar(s_o_core_o, INV_O));
         chk("R2", "out pad_oe", {7'd0, o_pad_oe}, {7'd0, s_o_oe});
         chk("R7", "out core_i", o_core_i, '0);
         chk("R6", "in pad_oe", {7'd0, i_pad_oe}, '0);
         chk("R6", "in pad_o", i_pad_o, '0);
      end
   endtask

   task automatic drive_snap(logic [W-1:0] co, logic coe, logic een, logic [W-1:0] ev);
      b_core_o  = co;
      b_core_oe = coe;
      ext_en    = een;
      ext_val   = ev;
      o_core_o  = W'($urandom);
      o_core_oe = ($urandom % 4) != 0;
      o_pin     = W'($urandom);
      i_core_o  = W'($urandom);
      i_core_oe = $urandom % 2;
      #1;
      if (b_pad_oe && ext_en) contention++;
      s_core_o   = b_core_o;
      s_oe       = b_core_oe;
      s_net      = pad_net;
      s_o_core_o = o_core_o;
      s_o_oe     = o_core_oe;
      have_snap  = 1;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] x, v1, v2;
      void'($urandom(32'd4242));
      #1;
      // R4 power-up enable values, R6 quiet input-only pads
      chk("R4", "bidir initial pad_oe", {7'd0, b_pad_oe}, 8'd0);
      chk("R4", "out initial pad_oe", {7'd0, o_pad_oe}, 8'd1);
      chk("R6", "in initial pad_oe", {7'd0, i_pad_oe}, 8'd0);

      // R5 directed loopback
      step(); drive_snap(8'h00, 1'b1, 1'b0, 8'h00);
      x = 8'h5A;
      step(); drive_snap(x, 1'b1, 1'b0, 8'h00);
      step(); drive_snap(8'hFF, 1'b1, 1'b0, 8'h00);
      step();
      chk("R5", "loopback core_i", b_core_i, x);
      drive_snap(8'h81, 1'b1, 1'b0, 8'h00);
      step();
      chk("R5", "loopback all-ones", b_core_i, 8'hFF);
      drive_snap(8'h81, 1'b0, 1'b0, 8'h00);

      // R9 random read and write bursts with one turn-around cycle
      for (int n = 0; n < 60; n++) begin
         int rl = 1 + ($urandom % 6);
         int wl = 1 + ($urandom % 6);
         for (int k = 0; k < rl; k++) begin
            step(); drive_snap(W'($urandom), 1'b1, 1'b0, ext_val);
         end
         step(); drive_snap(W'($urandom), 1'b0, 1'b0, ext_val);
         for (int k = 0; k < wl; k++) begin
            step(); drive_snap(W'($urandom), 1'b0, 1'b1, W'($urandom));
         end
      end
      // corner words on the far side
      step(); drive_snap(8'h00, 1'b0, 1'b1, 8'h00);
      step(); drive_snap(8'h00, 1'b0, 1'b1, 8'hFF);
      step(); drive_snap(8'h00, 1'b0, 1'b0, 8'hFF);
      step();
      chk("R9", "contention cycles", contention[W-1:0], '0);

      // R8 and R3 on the input-only instance with a hand-driven clock
      v1 = 8'hC3;
      i_pin = v1;
      #1 iclk = 1'b1;
      #1 iclk = 1'b0;
      #1;
      chk("R3", "in core_i after in edge", i_core_i, polar(v1, INV_I));
      v2 = 8'h96;
      i_pin = v2;
      repeat (4) @(posedge clk);
      #1;
      chk("R8", "in core_i held without in edge", i_core_i, polar(v1, INV_I));
      #1 iclk = 1'b1;
      #1 iclk = 1'b0;
      #1;
      chk("R8", "in core_i after next in edge", i_core_i, polar(v2, INV_I));

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule